// File: doc/BRIEF.md
# GPIO Interrupt Detection Bank

This block watches a bank of general-purpose input pins and turns selected pin activity into one interrupt line. Each pin is first brought into the local clock domain through a two-stage synchroniser. The synchronised level then feeds two detectors. An edge detector catches rising edges, falling edges or both. A level detector catches a high or a low level. A per-pin type bit chooses which of the two sets that pin's sticky status bit.

A status bit stays at 1 while its selected condition is present. Software clears it by writing 1 to that bit of the status register. The write only takes effect in a cycle where the condition is absent. A per-pin mask bit blocks the status bit from reaching the interrupt line, but detection keeps running underneath it. Events that arrive while a pin is masked therefore raise the line as soon as the mask is lifted. A small write and read port gives access to the configuration and status registers. The read side is combinational.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the type register reads 0 (all pins in level mode) and the polarity register reads all ones (active high or rising). The any-edge register reads 0, the mask register reads all ones (every pin blocked), the status register reads 0 and irq_out is 0.
- R2: A change on pin_in is sampled through two flip-flops. A pin that holds a new value from the cycle before clock edge k first affects status at edge k+2, and not earlier.
- R3: In level mode (type bit 0), a pin's status bit is set while its synchronised level equals its polarity bit: 1 means high and 0 means low.
- R4: In edge mode (type bit 1), the condition is true only in the one cycle after the synchronised level changes. With any-edge 1, both directions count. With any-edge 0, a polarity of 1 selects rising edges and a polarity of 0 selects falling edges.
- R5: Once set, a status bit stays 1 until it is acknowledged, even after its condition goes away.
- R6: Writing 1 to a status bit at address 4 clears it only if that pin's condition is absent in the write cycle. A 1 written while the condition is present, and any bit written as 0, leaves the status bit unchanged.
- R7: Mask bits (1 = blocked) do not stop detection or status setting. irq_out is 1 exactly when some pin has status 1 and mask 0.
- R8: Register addresses are type = 0, polarity = 1, any-edge = 2, mask = 3 and status = 4. Addresses 0 to 3 read back the last value written. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Raw asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data, one bit per pin |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| irq_out | output | 1 | Bank interrupt, OR of unmasked status bits |

## Verification
Status is state that persists across cycles. A wrong set or clear decision in one cycle therefore shows on the status readback at the next clock edge and stays visible until the next acknowledge. It also reaches irq_out in that same cycle whenever the pin is unmasked. A fault in the synchroniser or the edge history shifts the cycle in which status rises, by one or two cycles. For that reason every step compares status and irq_out against a cycle-accurate model. A wrong acknowledge gate becomes visible in the cycle straight after the acknowledging write.

// File: rtl/gib_pkg.sv
package gib_pkg;

    localparam int ADDR_W      = 3;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_TYPE = 3'd0,
        SEL_POL  = 3'd1,
        SEL_ANY  = 3'd2,
        SEL_MASK = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } wr_req_t;

    // pick the edge event a single pin reacts to
    function automatic logic edge_pick(input logic rise, input logic fall,
                                       input logic pol,  input logic any);
        if (any)
            return rise | fall;
        return pol ? rise : fall;
    endfunction

    // pick the level event a single pin reacts to
    function automatic logic level_pick(input logic lvl, input logic pol);
        return pol ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/gib_sync.sv
module gib_sync
    import gib_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= din;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage_q[SYNC_STAGES-1];

    logic [1:0] armed_q;
    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= '0;
        else if (armed_q != 2'd3)
            armed_q <= armed_q + 2'd1;
    end

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q == 2'd3) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gib_detect.sv
module gib_detect
    import gib_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] any,
    output logic [W-1:0] cond
);

    logic [W-1:0] prev_q;
    logic [W-1:0] edge_evt;
    logic [W-1:0] lvl_evt;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '0;
        else
            prev_q <= cur;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            logic rise, fall;
            always_comb begin
                rise        = cur[i] & ~prev_q[i];
                fall        = ~cur[i] & prev_q[i];
                edge_evt[i] = edge_pick(rise, fall, pol[i], any[i]);
                lvl_evt[i]  = level_pick(cur[i], pol[i]);
                cond[i]     = typ[i] ? edge_evt[i] : lvl_evt[i];
            end
        end
    endgenerate

    // R4
    edge_only_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        ((edge_evt & ~(cur ^ prev_q)) == '0));

    // R3
    level_follows_pin_chk: assert property (@(posedge clk) disable iff (rst)
        ((~typ & cond & ~(cur ~^ pol)) == '0));

endmodule

// File: rtl/gib_regs.sv
module gib_regs
    import gib_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [W-1:0]      cond,
    output logic [W-1:0]      typ,
    output logic [W-1:0]      pol,
    output logic [W-1:0]      any,
    output logic [W-1:0]      mask,
    output logic [W-1:0]      status,
    output logic [W-1:0]      rd_data
);

    logic [W-1:0] ack;

    always_comb begin
        ack = '0;
        if (wr.en && reg_sel_e'(wr.addr) == SEL_STAT)
            ack = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            typ  <= '0;
            pol  <= '1;
            any  <= '0;
            mask <= '1;
        end else if (wr.en) begin
            case (reg_sel_e'(wr.addr))
                SEL_TYPE: typ  <= wr_data;
                SEL_POL:  pol  <= wr_data;
                SEL_ANY:  any  <= wr_data;
                SEL_MASK: mask <= wr_data;
                default:  ;
            endcase
        end
    end

    // a live condition always wins over an acknowledge
    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= cond | (status & ~ack);
    end

    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_TYPE: rd_data = typ;
            SEL_POL:  rd_data = pol;
            SEL_ANY:  rd_data = any;
            SEL_MASK: rd_data = mask;
            SEL_STAT: rd_data = status;
            default:  rd_data = '0;
        endcase
    end

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(status) & ~$past(ack) & ~status) == '0));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((status & $past(ack) & ~$past(cond)) == '0));

    // R3
    status_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status) & ~$past(cond)) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gib_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NPINS-1:0]  rd_data,
    output logic              irq_out
);

    logic [NPINS-1:0] cur, cond;
    logic [NPINS-1:0] typ, pol, any, mask, status;
    wr_req_t          wr;

    assign wr.en   = wr_en;
    assign wr.addr = wr_addr;

    gib_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pin_in),
        .dout(cur)
    );

    gib_detect #(.W(NPINS)) u_detect (
        .clk (clk),
        .rst (rst),
        .cur (cur),
        .typ (typ),
        .pol (pol),
        .any (any),
        .cond(cond)
    );

    gib_regs #(.W(NPINS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .cond   (cond),
        .typ    (typ),
        .pol    (pol),
        .any    (any),
        .mask   (mask),
        .status (status),
        .rd_data(rd_data)
    );

    assign irq_out = |(status & ~mask);

    // R7
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (&mask) |-> !irq_out);

    // R7
    detect_under_mask_chk: assert property (@(posedge clk) disable iff (rst)
        ((mask & $past(cond) & ~status) == '0));

endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
    import gib_pkg::*;

    localparam int CLK_P = 10;
    localparam int N     = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  pin_in;
    logic          wr_en;
    logic [2:0]    wr_addr;
    logic [N-1:0]  wr_data;
    logic [2:0]    rd_addr;
    logic [N-1:0]  rd_data;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    logic [N-1:0] m_s1, m_s2, m_prev, m_st, m_typ, m_pol, m_any, m_mask;

    always #(CLK_P/2) clk = ~clk;

    gpio_irq_bank uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [N-1:0] exp_cond();
        logic [N-1:0] r, f, e, l;
        r = m_s2 & ~m_prev;
        f = ~m_s2 & m_prev;
        e = (m_any & (r | f)) | (~m_any & ((m_pol & r) | (~m_pol & f)));
        l = (m_pol & m_s2) | (~m_pol & ~m_s2);
        return (m_typ & e) | (~m_typ & l);
    endfunction

    task automatic step(input logic [N-1:0] p, input logic we = 1'b0,
                        input logic [2:0] a = 3'd0, input logic [N-1:0] d = '0);
        logic [N-1:0] ack;
        pin_in = p; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        ack  = (we && a == 3'd4) ? d : '0;
        m_st = exp_cond() | (m_st & ~ack);
        m_prev = m_s2; m_s2 = m_s1; m_s1 = p;
        if (we) begin
            case (a)
                3'd0: m_typ = d;
                3'd1: m_pol = d;
                3'd2: m_any = d;
                3'd3: m_mask = d;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic st_is(input string tag, input logic [N-1:0] exp, input logic ir);
        logic [N-1:0] v;
        rd(3'd4, v);
        chk(tag, v, exp);
        chk({tag, " irq"}, {31'd0, irq_out}, {31'd0, ir});
    endtask

    initial begin
        logic [N-1:0] v;
        logic [N-1:0] p;
        void'($urandom(32'd2024));
        rst = 1'b1; pin_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_st = '0;
        m_typ = '0; m_pol = '1; m_any = '0; m_mask = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(3'd0, v); chk("R1 type", v, '0);
        rd(3'd1, v); chk("R1 pol", v, '1);
        rd(3'd2, v); chk("R1 any", v, '0);
        rd(3'd3, v); chk("R1 mask", v, '1);
        st_is("R1 status", '0, 1'b0);

        // R2 / R3: level high on pin 0, two sync stages
        step('0, 1'b1, 3'd3, ~32'h1);
        step(32'h1); st_is("R2 edge1", '0, 1'b0);
        step(32'h1); st_is("R2 edge2", '0, 1'b0);
        step(32'h1); st_is("R3 level high set", 32'h1, 1'b1);
        // R6 ack while condition live is ignored
        step(32'h1, 1'b1, 3'd4, 32'h1); st_is("R6 ack ignored", 32'h1, 1'b1);
        step('0); step('0); st_is("R5 held", 32'h1, 1'b1);
        // R6 writing 0 bits does nothing
        step('0, 1'b1, 3'd4, 32'h0); st_is("R6 zero write", 32'h1, 1'b1);
        step('0, 1'b1, 3'd4, 32'h1); st_is("R6 ack clears", '0, 1'b0);

        // R3 low polarity on pin 1
        step('0, 1'b1, 3'd1, ~32'h2);
        step('0, 1'b1, 3'd3, ~32'h3); st_is("R3 level low set", 32'h2, 1'b1);
        step('0, 1'b1, 3'd1, '1);
        step('0, 1'b1, 3'd4, 32'h2); st_is("R6 low cleared", '0, 1'b0);

        // R4 edge mode on pin 2
        step('0, 1'b1, 3'd0, 32'h4);
        step('0, 1'b1, 3'd3, ~32'h7);
        step(32'h4); step(32'h4); step(32'h4); st_is("R4 rising", 32'h4, 1'b1);
        step(32'h4, 1'b1, 3'd4, 32'h4); st_is("R4 ack after edge", '0, 1'b0);
        step('0); step('0); step('0); st_is("R4 fall ignored pol1", '0, 1'b0);
        step('0, 1'b1, 3'd1, ~32'h4);
        step(32'h4); step(32'h4); step(32'h4); st_is("R4 rise ignored pol0", '0, 1'b0);
        step('0); step('0); step('0); st_is("R4 falling", 32'h4, 1'b1);
        step('0, 1'b1, 3'd4, 32'h4);
        step('0, 1'b1, 3'd2, 32'h4);
        step(32'h4); step(32'h4); step(32'h4); st_is("R4 any rise", 32'h4, 1'b1);
        step(32'h4, 1'b1, 3'd4, 32'h4);
        step('0); step('0); step('0); st_is("R4 any fall", 32'h4, 1'b1);
        step('0, 1'b1, 3'd4, 32'h4);

        // R7 masked pin 3 still detects
        step(32'h8); step(32'h8); step(32'h8); st_is("R7 masked detect", 32'h8, 1'b0);
        step(32'h8, 1'b1, 3'd3, ~32'hF); st_is("R7 unmask raises", 32'h8, 1'b1);

        // R8 readback and unmapped addresses
        step(32'h8, 1'b1, 3'd2, 32'hA5A5_0F0F);
        rd(3'd2, v); chk("R8 any rb", v, 32'hA5A5_0F0F);
        step(32'h8, 1'b1, 3'd0, 32'h1234_5678);
        rd(3'd0, v); chk("R8 type rb", v, 32'h1234_5678);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v); chk("R8 unmapped", v, '0);
        end

        // random mix against the model
        p = 32'h8;
        for (int k = 0; k < 400; k++) begin
            int r;
            if ($urandom % 3 == 0) p = p ^ $urandom;
            r = $urandom % 8;
            if (r < 4)
                step(p, 1'b1, 3'(r == 3 ? 4 : r), $urandom);
            else if (r == 4)
                step(p, 1'b1, 3'd3, $urandom);
            else
                step(p);
            st_is("R3 R4 R5 R6 R7 random", m_st, |(m_st & ~m_mask));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule